// File: doc/BRIEF.md
# Processor Status and Interrupt Control

This block keeps the live processor status word and two saved copies of it. One copy holds the state from before an ordinary exception and the other holds the state from before a debug break. It also holds a 32-line interrupt enable mask and a pending view of the interrupt lines, and it raises a registered request when an enabled interrupt is waiting and interrupts are globally on. The pipeline reports exceptions, breaks and the two kinds of return through single-cycle strobes. Software reaches the registers through a small control-register read/write port, which only works in supervisor mode.

The status word has three fields: the global interrupt enable, the user-mode flag and the handler-active flag. The handler-active flag is exported so that the address translation logic can tell a first translation miss from a miss taken inside a handler. The mode and interrupt-enable flags are exported for privilege checks and interrupt gating.

Top module: `cpu_status_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every status field, both saved copies and the enable mask are 0, and so are user_mode_o, exc_handler_o, int_en_o, irq_req_o, csr_illegal_o and csr_rdata_o.
- R2: An exception strobe copies the status word into the exception save copy. From the next cycle the status has handler-active=1, user=0 and interrupt-enable=0.
- R3: The exception-return strobe loads the status word from the exception save copy.
- R4: A break strobe copies status into the break save copy and enters the same handler state as R2. The break-return strobe loads status from the break save copy.
- R5: If a break and an exception strobe arrive in the same cycle, the break is taken: the break copy is written and the exception copy keeps its value.
- R6: Status word layout: bit 0 is interrupt-enable, bit 1 is user mode, bit 2 is handler-active. All other bits read as 0 and ignore writes.
- R7: The enable mask is read/write, and bit n enables interrupt line n.
- R8: The pending register returns the interrupt lines as sampled one clock earlier. Writes to it have no effect.
- R9: irq_req_o is 1 in the cycle after the pending sample exactly when interrupt-enable=1 and (pending AND enable) is nonzero.
- R10: A read or write attempted while user=1 changes no state. In the next cycle csr_illegal_o is 1 and csr_rdata_o is 0.
- R11: Register indices are: 0 status, 1 exception save copy, 2 break save copy, 3 enable mask, 4 pending. A read of any other index returns 0, and a write to one is ignored. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_i | input | 1 | Ordinary exception entry strobe |
| brk_i | input | 1 | Debug break entry strobe |
| eret_i | input | 1 | Return from exception strobe |
| bret_i | input | 1 | Return from break strobe |
| csr_we_i | input | 1 | Control register write strobe |
| csr_re_i | input | 1 | Control register read strobe |
| csr_addr_i | input | 5 | Control register index |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Registered read data |
| csr_illegal_o | output | 1 | Access attempted in user mode (registered) |
| irq_i | input | 32 | Interrupt lines |
| user_mode_o | output | 1 | Current user-mode flag |
| exc_handler_o | output | 1 | Current handler-active flag |
| int_en_o | output | 1 | Current global interrupt enable |
| irq_req_o | output | 1 | Interrupt take request |

## Verification
The bench targets the save and restore paths. It moves between user and supervisor through exceptions and breaks, so that a design which swaps the two saved copies, or which restores from the wrong one, returns the wrong mode. It strobes a break and an exception together: a wrong priority shows up as an overwritten exception copy. Accesses made in user mode must leave the enable mask unchanged, and a design that lets them through shows a changed mask once supervisor mode is back. The interrupt request is checked with lines that are not enabled, with the global enable off, and after exception entry, which must drop the request.

// File: rtl/psr_pkg.sv
package psr_pkg;
  // bit 2 handler-active, bit 1 user, bit 0 interrupt enable
  typedef struct packed {
    logic eh;
    logic u;
    logic pie;
  } psr_t;

  localparam int unsigned PSR_W = 3;

  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_ESAVE  = 1;
  localparam int unsigned IDX_BSAVE  = 2;
  localparam int unsigned IDX_IEN    = 3;
  localparam int unsigned IDX_IPEND  = 4;

  localparam psr_t PSR_ENTRY = '{eh: 1'b1, u: 1'b0, pie: 1'b0};
endpackage

// File: rtl/psr_status_core.sv
module psr_status_core
  import psr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic exc_i,
  input  logic brk_i,
  input  logic eret_i,
  input  logic bret_i,
  input  logic wr_status,
  input  logic wr_esave,
  input  logic wr_bsave,
  input  psr_t wdata,
  output psr_t status_o,
  output psr_t esave_o,
  output psr_t bsave_o
);
  psr_t cur_q, esv_q, bsv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      esv_q <= '0;
      bsv_q <= '0;
    end else if (brk_i) begin
      bsv_q <= cur_q;
      cur_q <= PSR_ENTRY;
    end else if (exc_i) begin
      esv_q <= cur_q;
      cur_q <= PSR_ENTRY;
    end else begin
      if (bret_i)         cur_q <= bsv_q;
      else if (eret_i)    cur_q <= esv_q;
      else if (wr_status) cur_q <= wdata;
      if (wr_esave) esv_q <= wdata;
      if (wr_bsave) bsv_q <= wdata;
    end
  end

  assign status_o = cur_q;
  assign esave_o  = esv_q;
  assign bsave_o  = bsv_q;

  assert_entry_super_R2: assert property (@(posedge clk) disable iff (rst)
    (exc_i || brk_i) |=> (cur_q.eh && !cur_q.u && !cur_q.pie));

  assert_eret_restore_R3: assert property (@(posedge clk) disable iff (rst)
    (eret_i && !exc_i && !brk_i && !bret_i) |=> (cur_q == $past(esv_q)));

  assert_brk_save_R4: assert property (@(posedge clk) disable iff (rst)
    brk_i |=> (bsv_q == $past(cur_q)));

  assert_brk_prio_R5: assert property (@(posedge clk) disable iff (rst)
    (brk_i && exc_i) |=> $stable(esv_q));
endmodule

// File: rtl/psr_irq_unit.sv
module psr_irq_unit #(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               wr_en,
  input  logic [NUM_IRQ-1:0] wdata,
  input  logic               pie,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] en_o,
  output logic               req_o
);
  logic [NUM_IRQ-1:0] pend_q, en_q, live;
  logic               req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= irq_i;
      if (wr_en) en_q <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign live[i] = pend_q[i] & en_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= pie & (|live);
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign req_o  = req_q;

  assert_req_gated_R9: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(pie));
endmodule

// File: rtl/psr_csr_port.sv
module psr_csr_port
  import psr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               user_i,
  input  psr_t               status_i,
  input  psr_t               esave_i,
  input  psr_t               bsave_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] pend_i,
  output logic               wr_status,
  output logic               wr_esave,
  output logic               wr_bsave,
  output logic               wr_en,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               illegal_o
);
  logic              legal;
  logic [DATA_W-1:0] rmux;
  logic [DATA_W-1:0] rdata_q;
  logic              ill_q;

  assign legal     = !user_i;
  assign wr_status = we_i && legal && (addr_i == ADDR_W'(IDX_STATUS));
  assign wr_esave  = we_i && legal && (addr_i == ADDR_W'(IDX_ESAVE));
  assign wr_bsave  = we_i && legal && (addr_i == ADDR_W'(IDX_BSAVE));
  assign wr_en     = we_i && legal && (addr_i == ADDR_W'(IDX_IEN));

  always_comb begin
    rmux = '0;
    case (addr_i)
      ADDR_W'(IDX_STATUS): rmux = DATA_W'(status_i);
      ADDR_W'(IDX_ESAVE):  rmux = DATA_W'(esave_i);
      ADDR_W'(IDX_BSAVE):  rmux = DATA_W'(bsave_i);
      ADDR_W'(IDX_IEN):    rmux = DATA_W'(en_i);
      ADDR_W'(IDX_IPEND):  rmux = DATA_W'(pend_i);
      default:             rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      ill_q   <= 1'b0;
    end else begin
      rdata_q <= (re_i && legal) ? rmux : '0;
      ill_q   <= (re_i || we_i) && !legal;
    end
  end

  assign rdata_o   = rdata_q;
  assign illegal_o = ill_q;

  assert_user_block_R10: assert property (@(posedge clk) disable iff (rst)
    ((re_i || we_i) && user_i) |=> (ill_q && rdata_q == '0));
endmodule

// File: rtl/cpu_status_ctrl.sv
module cpu_status_ctrl
  import psr_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_i,
  input  logic               brk_i,
  input  logic               eret_i,
  input  logic               bret_i,
  input  logic               csr_we_i,
  input  logic               csr_re_i,
  input  logic [ADDR_W-1:0]  csr_addr_i,
  input  logic [DATA_W-1:0]  csr_wdata_i,
  output logic [DATA_W-1:0]  csr_rdata_o,
  output logic               csr_illegal_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic               user_mode_o,
  output logic               exc_handler_o,
  output logic               int_en_o,
  output logic               irq_req_o
);
  psr_t               status, esave, bsave, wpsr;
  logic               wr_status, wr_esave, wr_bsave, wr_en;
  logic [NUM_IRQ-1:0] en, pend;

  assign wpsr = psr_t'(csr_wdata_i[PSR_W-1:0]);

  psr_status_core u_core (
    .clk(clk), .rst(rst),
    .exc_i(exc_i), .brk_i(brk_i), .eret_i(eret_i), .bret_i(bret_i),
    .wr_status(wr_status), .wr_esave(wr_esave), .wr_bsave(wr_bsave),
    .wdata(wpsr),
    .status_o(status), .esave_o(esave), .bsave_o(bsave)
  );

  psr_irq_unit #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk(clk), .rst(rst), .irq_i(irq_i),
    .wr_en(wr_en), .wdata(csr_wdata_i[NUM_IRQ-1:0]),
    .pie(status.pie),
    .pend_o(pend), .en_o(en), .req_o(irq_req_o)
  );

  psr_csr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_port (
    .clk(clk), .rst(rst),
    .we_i(csr_we_i), .re_i(csr_re_i), .addr_i(csr_addr_i),
    .user_i(status.u),
    .status_i(status), .esave_i(esave), .bsave_i(bsave),
    .en_i(en), .pend_i(pend),
    .wr_status(wr_status), .wr_esave(wr_esave), .wr_bsave(wr_bsave), .wr_en(wr_en),
    .rdata_o(csr_rdata_o), .illegal_o(csr_illegal_o)
  );

  assign user_mode_o   = status.u;
  assign exc_handler_o = status.eh;
  assign int_en_o      = status.pie;
endmodule

// File: tb/sim_cpu_status_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_status_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_i = 0, brk_i = 0, eret_i = 0, bret_i = 0;
  logic        csr_we_i = 0, csr_re_i = 0;
  logic [4:0]  csr_addr_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        csr_illegal_o;
  logic [31:0] irq_i = '0;
  logic        user_mode_o, exc_handler_o, int_en_o, irq_req_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit due = 0;

  typedef struct {
    string       req;
    logic [31:0] data;
    logic        ill;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  cpu_status_ctrl u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare read results against the scoreboard queue
  always @(posedge clk) due <= csr_re_i;
  always @(negedge clk) begin
    if (due) begin
      if (q.size() == 0) begin
        check("queue", 32'h1, 32'h0);
      end else begin
        item_t it;
        it = q.pop_front();
        check({it.req, " rdata"}, csr_rdata_o, it.data);
        check({it.req, " illegal"}, {31'b0, csr_illegal_o}, {31'b0, it.ill});
      end
    end
  end

  task automatic csr_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    csr_we_i = 1; csr_addr_i = a; csr_wdata_i = d;
    @(negedge clk);
    csr_we_i = 0;
  endtask

  task automatic csr_rd(logic [4:0] a, logic [31:0] exp, logic ill, string req);
    item_t it;
    @(negedge clk);
    csr_re_i = 1; csr_addr_i = a;
    it.req = req; it.data = exp; it.ill = ill;
    q.push_back(it);
    @(negedge clk);
    csr_re_i = 0;
  endtask

  task automatic strobe(bit e, bit b, bit er, bit br);
    @(negedge clk);
    exc_i = e; brk_i = b; eret_i = er; bret_i = br;
    @(negedge clk);
    exc_i = 0; brk_i = 0; eret_i = 0; bret_i = 0;
  endtask

  task automatic set_irq(logic [31:0] v);
    @(negedge clk);
    irq_i = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_flags(string req, bit u, bit eh, bit pie);
    check({req, " user"}, {31'b0, user_mode_o}, {31'b0, u});
    check({req, " eh"},   {31'b0, exc_handler_o}, {31'b0, eh});
    check({req, " pie"},  {31'b0, int_en_o}, {31'b0, pie});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_flags("R1", 0, 0, 0);
    check("R1 req", {31'b0, irq_req_o}, 32'h0);
    check("R1 illegal", {31'b0, csr_illegal_o}, 32'h0);
    check("R1 rdata", csr_rdata_o, 32'h0);
    csr_rd(0, 32'h0, 0, "R1 status");
    csr_rd(3, 32'h0, 0, "R1 enable");

    // R6 layout, undefined bits
    csr_wr(0, 32'hFFFF_FFF9);
    chk_flags("R6", 0, 0, 1);
    csr_rd(0, 32'h1, 0, "R6 status");

    // R7 enable mask
    csr_wr(3, 32'h0000_0010);
    csr_rd(3, 32'h0000_0010, 0, "R7 enable");

    // R9 request
    set_irq(32'h10);
    check("R9 enabled line", {31'b0, irq_req_o}, 32'h1);
    set_irq(32'h01);
    check("R9 masked line", {31'b0, irq_req_o}, 32'h0);
    set_irq(32'h11);
    check("R9 mixed", {31'b0, irq_req_o}, 32'h1);
    csr_wr(0, 32'h0);
    @(negedge clk);
    check("R9 pie off", {31'b0, irq_req_o}, 32'h0);
    csr_wr(0, 32'h1);
    @(negedge clk);
    check("R9 pie on", {31'b0, irq_req_o}, 32'h1);

    // R8 pending
    csr_rd(4, 32'h11, 0, "R8 pending");
    csr_wr(4, 32'h0);
    csr_rd(4, 32'h11, 0, "R8 write ignored");

    // R11 unmapped
    csr_wr(9, 32'hFFFF_FFFF);
    csr_rd(9, 32'h0, 0, "R11 unmapped");
    csr_rd(0, 32'h1, 0, "R11 status intact");
    csr_rd(3, 32'h10, 0, "R11 enable intact");

    // R2 exception entry
    strobe(1, 0, 0, 0);
    chk_flags("R2", 0, 1, 0);
    @(negedge clk);
    check("R2 req dropped", {31'b0, irq_req_o}, 32'h0);
    csr_rd(1, 32'h1, 0, "R2 esave");

    // R3 return
    strobe(0, 0, 1, 0);
    chk_flags("R3", 0, 0, 1);

    // R10 user mode access
    csr_wr(0, 32'h3);
    chk_flags("R10 enter user", 1, 0, 1);
    csr_wr(3, 32'hFFFF_FFFF);
    check("R10 illegal on write", {31'b0, csr_illegal_o}, 32'h1);
    csr_rd(0, 32'h0, 1, "R10 user read");
    strobe(1, 0, 0, 0);
    chk_flags("R10 back to super", 0, 1, 0);
    csr_rd(3, 32'h10, 0, "R10 enable unchanged");
    csr_rd(1, 32'h3, 0, "R10 esave");

    // R4 break save/restore
    strobe(0, 0, 1, 0);
    chk_flags("R4 eret user", 1, 0, 1);
    strobe(0, 1, 0, 0);
    chk_flags("R4 break entry", 0, 1, 0);
    csr_rd(2, 32'h3, 0, "R4 bsave");
    csr_rd(1, 32'h3, 0, "R4 esave kept");
    strobe(0, 0, 0, 1);
    chk_flags("R4 bret", 1, 0, 1);
    strobe(0, 1, 0, 0);

    // R5 simultaneous break and exception
    csr_wr(1, 32'h0);
    strobe(1, 1, 0, 0);
    chk_flags("R5", 0, 1, 0);
    csr_rd(1, 32'h0, 0, "R5 esave unchanged");
    csr_rd(2, 32'h4, 0, "R5 bsave written");

    repeat (3) @(negedge clk);
    check("queue drained", q.size(), 32'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule